// File: doc/BRIEF.md
# Loadable LFSR Interval Timer

This block times intervals with a 9-bit maximal-length shift register in place of a loadable binary down-counter. A preset state is loaded, and the register then takes one step on each clock where the step enable is high. The terminal state is all zeros. When the register reaches it, a registered done flag rises two clock edges later. The next-state loop is a single two-way choice: take the preset, or take the shifted value with its feedback bit. There is no carry chain. The wide zero compare sits outside that loop, in a two-stage pipeline.

The controller is a small state machine with three states. `IDLE` is entered at reset, and the register holds there. A load moves the machine from any state to `COUNT`, where the register steps on enable. The transition from `COUNT` to `HALTED` fires when the pipelined compare reports a zero state, and it raises done. In `HALTED` the register and the flag hold until the next load. Because the compare lags, the register can still step on the two edges that follow the zero state. A caller who needs exact timing plans presets with that lag in mind.

Top module: `lfsr_countdown`

## Requirements
- R1: Synchronous reset sets `count` to 0 and `done` to 0, and enters `IDLE`. In `IDLE` the register does not step, even while `step_en` is high.
- R2: When `load` is high on an edge, `count` takes `preset` and `done` clears to 0, whatever `step_en` is. This applies in every state.
- R3: In `COUNT` with `step_en` high, one edge turns `count` into {count[7:0], fb}, where fb = NOT(count[8] XOR count[4]).
- R4: In `COUNT` with `step_en` low, `count` holds its value.
- R5: While counting, `done` rises exactly two edges after the edge at which `count` became 0.
- R6: After `done` rises, `count` is frozen and `done` stays 1 until the next load, whatever `step_en` does.
- R7: A load flushes the compare pipeline. If a nonzero preset is loaded on the edge right after `count` became 0, `done` does not rise.
- R8: The all-ones value 0x1FF is a lockup state. Once loaded, it is never left by stepping, and it never raises `done`.
- R9: The sequence has period 511. After a load of 0x001 with `step_en` held high, `done` is first 1 after the 512th edge following the load edge.
- R10: Reset has priority over load. With `rst` and `load` both high, `count` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load strobe; has priority over step_en |
| preset | input | 9 | Value taken by the register on a load |
| step_en | input | 1 | Step enable while counting |
| count | output | 9 | Current register state |
| done | output | 1 | Registered terminal flag, sticky until the next load |

## Verification
A wrong feedback tap or shift direction shows at `count` on the first stepping edge after a load. A wrong compare group or a missing flush shows as `done` rising one or more cycles early or late, or rising spuriously after a reload. A bad halt or hold path shows as `count` changing after `done` is high, or while `step_en` is low. Each of these faults differs from the cycle-by-cycle model within at most a few edges of the stimulus that exposes it. The only exception is the period fault, which needs the full 511-step run to show.

// File: rtl/lfsr_cd_pkg.sv
package lfsr_cd_pkg;
    typedef enum logic [1:0] {
        CD_IDLE   = 2'd0,
        CD_COUNT  = 2'd1,
        CD_HALTED = 2'd2
    } cd_mode_t;

    localparam int CD_WIDTH  = 9;
    localparam int CD_TAP_HI = 8;
    localparam int CD_TAP_LO = 4;
    localparam int CD_GROUP  = 3;
endpackage

// File: rtl/lfsr_cd_shift.sv
module lfsr_cd_shift #(
    parameter int W      = lfsr_cd_pkg::CD_WIDTH,
    parameter int TAP_HI = lfsr_cd_pkg::CD_TAP_HI,
    parameter int TAP_LO = lfsr_cd_pkg::CD_TAP_LO
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] preset,
    input  logic         advance,
    output logic [W-1:0] state_q
);
    logic         fb;
    logic [W-1:0] state_d;

    // XNOR feedback keeps all-zeros inside the sequence
    assign fb = ~(state_q[TAP_HI] ^ state_q[TAP_LO]);

    always_comb begin
        if (load)
            state_d = preset;
        else if (advance)
            state_d = {state_q[W-2:0], fb};
        else
            state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/lfsr_cd_zdet.sv
module lfsr_cd_zdet #(
    parameter int W  = lfsr_cd_pkg::CD_WIDTH,
    parameter int GW = lfsr_cd_pkg::CD_GROUP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [W-1:0] value,
    output logic         hit
);
    localparam int NGRP = (W + GW - 1) / GW;

    logic [NGRP-1:0] grp_zero;
    logic [NGRP-1:0] grp_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GW;
        localparam int HI = ((LO + GW) > W) ? (W - 1) : (LO + GW - 1);
        assign grp_zero[g] = ~|value[HI:LO];
    end

    // stage one: per-group zero flags, cleared on a load
    always_ff @(posedge clk) begin
        if (rst || flush)
            grp_q <= '0;
        else
            grp_q <= grp_zero;
    end

    // stage two is the controller's registered transition
    assign hit = &grp_q;
endmodule

// File: rtl/lfsr_cd_ctrl.sv
module lfsr_cd_ctrl
    import lfsr_cd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     step_en,
    input  logic     hit,
    output logic     advance,
    output logic     done_q,
    output cd_mode_t mode_q
);
    cd_mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d = CD_COUNT;
        end else begin
            unique case (mode_q)
                CD_IDLE:   mode_d = CD_IDLE;
                CD_COUNT:  if (hit) mode_d = CD_HALTED;
                CD_HALTED: mode_d = CD_HALTED;
                default:   mode_d = CD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= CD_IDLE;
        else
            mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (rst || load)
            done_q <= 1'b0;
        else if (mode_q == CD_COUNT && hit)
            done_q <= 1'b1;
    end

    assign advance = (mode_q == CD_COUNT) && step_en;
endmodule

// File: rtl/lfsr_countdown.sv
module lfsr_countdown
    import lfsr_cd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [CD_WIDTH-1:0] preset,
    input  logic                step_en,
    output logic [CD_WIDTH-1:0] count,
    output logic                done
);
    logic     advance;
    logic     hit;
    cd_mode_t mode_q;

    lfsr_cd_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step_en (step_en),
        .hit     (hit),
        .advance (advance),
        .done_q  (done),
        .mode_q  (mode_q)
    );

    lfsr_cd_shift #(.W(CD_WIDTH), .TAP_HI(CD_TAP_HI), .TAP_LO(CD_TAP_LO)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .preset  (preset),
        .advance (advance),
        .state_q (count)
    );

    lfsr_cd_zdet #(.W(CD_WIDTH), .GW(CD_GROUP)) u_zdet (
        .clk   (clk),
        .rst   (rst),
        .flush (load),
        .value (count),
        .hit   (hit)
    );
endmodule

// File: rtl/lfsr_countdown_chk.sv
module lfsr_countdown_chk
    import lfsr_cd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                load,
    input logic [CD_WIDTH-1:0] preset,
    input logic                step_en,
    input logic [CD_WIDTH-1:0] count,
    input logic                done,
    input cd_mode_t            mode_q
);
    p_reset_r1: assert property (@(posedge clk) rst |=> (count == '0) && !done);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(preset)) && !done);

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && mode_q == CD_COUNT) |=>
        (count == {$past(count[7:0]), ~($past(count[8]) ^ $past(count[4]))}));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_en) |=> $stable(count));

    p_lag_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(count, 2) == '0));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done && $stable(count));

    p_lockup_r8: assert property (@(posedge clk) disable iff (rst)
        (count == 9'h1FF && !load && !done) |=> (count == 9'h1FF) && !done);
endmodule

bind lfsr_countdown lfsr_countdown_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .preset  (preset),
    .step_en (step_en),
    .count   (count),
    .done    (done),
    .mode_q  (mode_q)
);

// File: tb/lfsr_countdown_test.sv
module lfsr_countdown_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [8:0] preset = '0;
    logic       step_en = 1'b0;
    logic [8:0] count;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [8:0] exp_s[$];
    logic       exp_d[$];
    string      exp_t[$];

    // reference model state
    logic [8:0] m_s = '0;
    logic [2:0] m_g = '0;
    int         m_mode = 0;
    logic       m_d = 1'b0;

    lfsr_countdown uut (
        .clk(clk), .rst(rst), .load(load), .preset(preset),
        .step_en(step_en), .count(count), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [8:0] nxt(input logic [8:0] s);
        return {s[7:0], ~(s[8] ^ s[4])};
    endfunction

    task automatic model(input logic r, input logic l, input logic [8:0] v, input logic e);
        logic [2:0] og;
        if (r) begin
            m_s = '0; m_g = '0; m_mode = 0; m_d = 0;
        end else if (l) begin
            m_s = v; m_g = '0; m_mode = 1; m_d = 0;
        end else begin
            og = m_g;
            m_g = {m_s[8:6] == 3'b0, m_s[5:3] == 3'b0, m_s[2:0] == 3'b0};
            if (m_mode == 1) begin
                if (e) m_s = nxt(m_s);
                if (&og) begin m_mode = 2; m_d = 1; end
            end
        end
    endtask

    task automatic tick(input logic r, input logic l, input logic [8:0] v,
                        input logic e, input string tag);
        @(negedge clk);
        rst = r; load = l; preset = v; step_en = e;
        model(r, l, v, e);
        exp_s.push_back(m_s);
        exp_d.push_back(m_d);
        exp_t.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (exp_s.size() > 0) begin
            logic [8:0] es;
            logic       ed;
            string      et;
            es = exp_s.pop_front();
            ed = exp_d.pop_front();
            et = exp_t.pop_front();
            n_cmp++;
            if (count !== es || done !== ed) begin
                n_bad++;
                $display("FAIL %s: count=%h done=%b expected count=%h done=%b",
                         et, count, done, es, ed);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R10 / R1: reset beats load, then idle does not step
        tick(1, 1, 9'h055, 1, "R10 reset over load");
        tick(1, 0, 9'h000, 1, "R1 reset state");
        for (int i = 0; i < 4; i++) tick(0, 0, 9'h000, 1, "R1 idle holds");

        // R5 / R6: 0x100 steps to zero, done two edges later, then frozen
        tick(0, 1, 9'h100, 1, "R2 load 0x100");
        for (int i = 0; i < 8; i++) tick(0, 0, 9'h000, 1, "R5 R6 terminal and freeze");

        // R4 / R3: enable gaps on the way to zero
        tick(0, 1, 9'h1C0, 0, "R2 load 0x1C0");
        for (int i = 0; i < 12; i++) tick(0, 0, 9'h000, i[0], "R4 R3 gapped stepping");

        // R2: load in halted state while enable high
        tick(0, 1, 9'h0AA, 1, "R2 reload from halted");
        for (int i = 0; i < 10; i++) tick(0, 0, 9'h000, 1, "R3 stepping 0x0AA");
        tick(0, 1, 9'h010, 1, "R2 load 0x010");
        for (int i = 0; i < 6; i++) tick(0, 0, 9'h000, 1, "R3 tap bit 4");

        // R7: reload one edge after reaching zero
        tick(0, 1, 9'h100, 1, "R2 load 0x100");
        tick(0, 0, 9'h000, 1, "R7 reach zero");
        tick(0, 1, 9'h0AA, 1, "R7 reload flushes");
        for (int i = 0; i < 6; i++) tick(0, 0, 9'h000, 1, "R7 no spurious done");

        // R8: lockup
        tick(0, 1, 9'h1FF, 1, "R8 load lockup");
        for (int i = 0; i < 6; i++) tick(0, 0, 9'h000, 1, "R8 lockup holds");

        // R9: period from 0x001
        tick(0, 1, 9'h001, 1, "R9 load 0x001");
        n = 0;
        while (!done && n < 600) begin
            tick(0, 0, 9'h000, 1, "R9 long run");
            n++;
        end
        #2;
        n_cmp++;
        if (n != 512) begin
            n_bad++;
            $display("FAIL R9 period: edges to done=%0d expected=%0d", n, 512);
        end

        @(posedge clk);
        #5;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule